// File: doc/BRIEF.md
# Cache Fill Error Capture Registers

This block watches the fill path of a cache. When a fill that serves a load or load-locked instruction returns a quadword with an uncorrectable error-detection-code fault, it records the diagnostic state of that fill. The state is the physical block address, the quadword index, the syndrome, whether the reference came from the instruction or the data stream and, for data-stream loads, the low address bits of the load, the destination register and the load type. The first such error loads the capture registers and locks them. It also sends a one-cycle machine-check pulse to the core.

While the capture is locked, further uncorrectable fills leave the captured fields alone and set only a multiple-error flag. Software reads the four registers through a 2-bit select. To release the lock, it writes a one to the fill-error bit of the status register. The fill data itself passes to the cache unchanged, and the block is still marked valid whether or not the fill had an error.

Top module: `fill_err_capture`

## Requirements
- R1: A fill updates the capture only when `fill_vld_i`, `fill_unc_i` and `fill_load_i` are all high. A fill with `fill_load_i` low, or with `fill_unc_i` low, changes no register and raises no machine check.
- R2: The first qualifying error, taken while unlocked, sets the fill-error bit (status bit 0), locks the capture and drives `mchk_o` high for exactly the next cycle. No other error drives `mchk_o`.
- R3: Status bit 2 is set when the captured error came from the instruction stream (`fill_istr_i`=1) and is cleared for a data-stream error.
- R4: A qualifying error that arrives while the capture is locked sets the multiple-error bit (status bit 1). It changes no captured field and raises no machine check.
- R5: Address register (select 1) bits 31:3 hold the physical address bits 33:5 of the failing fill. Status bits 4:3 hold the quadword index within the block.
- R6: For a data-stream error, address register bits 2:0 hold the load's physical address bits 4:2. For an instruction-stream error, these bits read zero.
- R7: Syndrome register (select 2) bits 7:0 hold the 8 check-syndrome bits of the failing quadword.
- R8: For a data-stream error, the load status register (select 3) holds the destination register number in bits 4:0. Bits 8:5 hold the load-type flags, from bit 5 upward: longword, lock, integer, floating format. An instruction-stream error leaves this register's contents undefined.
- R9: Writing `wr_err_i`=1 with `wr_en_i` high and `wr_sel_i`=0 clears the fill-error and multiple-error bits and releases the lock. If a qualifying error arrives in the same cycle, it is captured as a new first error.
- R10: `cache_valid_o` and `cache_data_o` follow `fill_vld_i` and `fill_data_i` unchanged, regardless of any error flag.
- R11: After reset, all four registers read zero and `mchk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld_i | input | 1 | Fill quadword valid strobe |
| fill_unc_i | input | 1 | Uncorrectable error on this quadword |
| fill_load_i | input | 1 | Fill serves a load or load-locked instruction |
| fill_istr_i | input | 1 | 1 = instruction stream, 0 = data stream |
| fill_pa_i | input | 29 | Physical address bits 33:5 |
| fill_qw_i | input | 2 | Quadword index within the block |
| fill_syn_i | input | 8 | Check-syndrome bits |
| fill_data_i | input | 64 | Fill data |
| ld_low_i | input | 3 | Load physical address bits 4:2 |
| ld_rn_i | input | 5 | Load destination register number |
| ld_type_i | input | 4 | Load-type flags {fp, int, lock, longword} |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register write select |
| wr_err_i | input | 1 | Value written to the fill-error bit |
| rd_sel_i | input | 2 | Register read select |
| rd_data_o | output | 32 | Selected register contents |
| mchk_o | output | 1 | Machine-check pulse |
| cache_valid_o | output | 1 | Block-valid to the cache |
| cache_data_o | output | 64 | Data to the cache |

## Verification
The assertions check on every cycle that a machine check arises only when the capture goes from unlocked to locked. They also check that a locked capture keeps its address, quadword and syndrome fields unless a clear arrives, that an error while locked sets the multiple-error flag, and that a non-load fill never takes the lock. Other behaviours show only in the bench's scenarios: the stream-dependent contents of the low address bits and the load status register, the layout of each register read, and the same-cycle clear-and-error case. The bench compares every readable register against its reference model while errors, clears and non-load fills are interleaved.

// File: rtl/fec_pkg.sv
package fec_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_SYND   = 2'd2,
        SEL_LDST   = 2'd3
    } fec_sel_e;

    localparam int ST_ERR   = 0;
    localparam int ST_MULTI = 1;
    localparam int ST_ISTR  = 2;
    localparam int ST_QW    = 3;
endpackage

// File: rtl/fec_capture.sv
module fec_capture #(
    parameter int PA_W  = 29,
    parameter int QW_W  = 2,
    parameter int SYN_W = 8,
    parameter int LOW_W = 3,
    parameter int RN_W  = 5,
    parameter int LT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             clr_i,
    input  logic             istr_i,
    input  logic [PA_W-1:0]  pa_i,
    input  logic [QW_W-1:0]  qw_i,
    input  logic [SYN_W-1:0] syn_i,
    input  logic [LOW_W-1:0] low_i,
    input  logic [RN_W-1:0]  rn_i,
    input  logic [LT_W-1:0]  lt_i,
    output logic             locked_o,
    output logic             multi_o,
    output logic             istr_o,
    output logic [QW_W-1:0]  qw_o,
    output logic [PA_W-1:0]  pa_o,
    output logic [LOW_W-1:0] low_o,
    output logic [SYN_W-1:0] syn_o,
    output logic [RN_W-1:0]  rn_o,
    output logic [LT_W-1:0]  lt_o,
    output logic             mchk_o
);
    typedef struct packed {
        logic             locked;
        logic             multi;
        logic             istr;
        logic [QW_W-1:0]  qw;
        logic [PA_W-1:0]  pa;
        logic [LOW_W-1:0] low;
        logic [SYN_W-1:0] syn;
        logic [RN_W-1:0]  rn;
        logic [LT_W-1:0]  lt;
        logic             mchk;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.mchk = 1'b0;
        if (clr_i) begin
            cap_d.locked = 1'b0;
            cap_d.multi  = 1'b0;
        end
        if (err_i) begin
            if (!cap_q.locked || clr_i) begin
                cap_d.locked = 1'b1;
                cap_d.multi  = 1'b0;
                cap_d.mchk   = 1'b1;
                cap_d.istr   = istr_i;
                cap_d.qw     = qw_i;
                cap_d.pa     = pa_i;
                cap_d.syn    = syn_i;
                if (istr_i) begin
                    cap_d.low = '0;
                end else begin
                    cap_d.low = low_i;
                    cap_d.rn  = rn_i;
                    cap_d.lt  = lt_i;
                end
            end else begin
                cap_d.multi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign locked_o = cap_q.locked;
    assign multi_o  = cap_q.multi;
    assign istr_o   = cap_q.istr;
    assign qw_o     = cap_q.qw;
    assign pa_o     = cap_q.pa;
    assign low_o    = cap_q.low;
    assign syn_o    = cap_q.syn;
    assign rn_o     = cap_q.rn;
    assign lt_o     = cap_q.lt;
    assign mchk_o   = cap_q.mchk;

    AST_MCHK_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !cap_q.locked) |=> (mchk_o && locked_o)); // R2
    AST_MCHK_ONLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_o |-> (locked_o && !multi_o)); // R2
    AST_MULTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && cap_q.locked && !clr_i) |=> (multi_o && !mchk_o)); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.locked && !clr_i) |=> ($stable(pa_o) && $stable(syn_o) && $stable(qw_o) && $stable(istr_o))); // R4
endmodule

// File: rtl/fec_readmux.sv
module fec_readmux
    import fec_pkg::*;
#(
    parameter int PA_W  = 29,
    parameter int QW_W  = 2,
    parameter int SYN_W = 8,
    parameter int LOW_W = 3,
    parameter int RN_W  = 5,
    parameter int LT_W  = 4,
    localparam int RD_W = PA_W + LOW_W
) (
    input  logic [1:0]       sel_i,
    input  logic             err_i,
    input  logic             multi_i,
    input  logic             istr_i,
    input  logic [QW_W-1:0]  qw_i,
    input  logic [PA_W-1:0]  pa_i,
    input  logic [LOW_W-1:0] low_i,
    input  logic [SYN_W-1:0] syn_i,
    input  logic [RN_W-1:0]  rn_i,
    input  logic [LT_W-1:0]  lt_i,
    output logic [RD_W-1:0]  data_o
);
    localparam int STAT_W = ST_QW + QW_W;

    always_comb begin
        unique case (fec_sel_e'(sel_i))
            SEL_STATUS: data_o = {{(RD_W-STAT_W){1'b0}}, qw_i, istr_i, multi_i, err_i};
            SEL_ADDR:   data_o = {pa_i, low_i};
            SEL_SYND:   data_o = {{(RD_W-SYN_W){1'b0}}, syn_i};
            SEL_LDST:   data_o = {{(RD_W-RN_W-LT_W){1'b0}}, lt_i, rn_i};
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/fill_err_capture.sv
module fill_err_capture
    import fec_pkg::*;
#(
    parameter int PA_HI = 33,
    parameter int PA_LO = 5,
    parameter int QW_W  = 2,
    parameter int SYN_W = 8,
    parameter int RN_W  = 5,
    parameter int LT_W  = 4,
    parameter int DAT_W = 64,
    localparam int PA_W  = PA_HI - PA_LO + 1,
    localparam int LOW_W = PA_LO - 2,
    localparam int RD_W  = PA_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld_i,
    input  logic             fill_unc_i,
    input  logic             fill_load_i,
    input  logic             fill_istr_i,
    input  logic [PA_W-1:0]  fill_pa_i,
    input  logic [QW_W-1:0]  fill_qw_i,
    input  logic [SYN_W-1:0] fill_syn_i,
    input  logic [DAT_W-1:0] fill_data_i,
    input  logic [LOW_W-1:0] ld_low_i,
    input  logic [RN_W-1:0]  ld_rn_i,
    input  logic [LT_W-1:0]  ld_type_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic             wr_err_i,
    input  logic [1:0]       rd_sel_i,
    output logic [RD_W-1:0]  rd_data_o,
    output logic             mchk_o,
    output logic             cache_valid_o,
    output logic [DAT_W-1:0] cache_data_o
);
    logic             err_ev, clr_ev;
    logic             locked, multi, istr;
    logic [QW_W-1:0]  qw;
    logic [PA_W-1:0]  pa;
    logic [LOW_W-1:0] low;
    logic [SYN_W-1:0] syn;
    logic [RN_W-1:0]  rn;
    logic [LT_W-1:0]  lt;

    assign err_ev = fill_vld_i && fill_unc_i && fill_load_i;
    assign clr_ev = wr_en_i && (fec_sel_e'(wr_sel_i) == SEL_STATUS) && wr_err_i;

    assign cache_valid_o = fill_vld_i;
    assign cache_data_o  = fill_data_i;

    fec_capture #(
        .PA_W(PA_W), .QW_W(QW_W), .SYN_W(SYN_W),
        .LOW_W(LOW_W), .RN_W(RN_W), .LT_W(LT_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .err_i(err_ev), .clr_i(clr_ev),
        .istr_i(fill_istr_i), .pa_i(fill_pa_i), .qw_i(fill_qw_i),
        .syn_i(fill_syn_i), .low_i(ld_low_i), .rn_i(ld_rn_i), .lt_i(ld_type_i),
        .locked_o(locked), .multi_o(multi), .istr_o(istr), .qw_o(qw),
        .pa_o(pa), .low_o(low), .syn_o(syn), .rn_o(rn), .lt_o(lt),
        .mchk_o(mchk_o)
    );

    fec_readmux #(
        .PA_W(PA_W), .QW_W(QW_W), .SYN_W(SYN_W),
        .LOW_W(LOW_W), .RN_W(RN_W), .LT_W(LT_W)
    ) u_rd (
        .sel_i(rd_sel_i), .err_i(locked), .multi_i(multi), .istr_i(istr),
        .qw_i(qw), .pa_i(pa), .low_i(low), .syn_i(syn), .rn_i(rn), .lt_i(lt),
        .data_o(rd_data_o)
    );

    AST_NONLOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(fill_vld_i && fill_unc_i && fill_load_i)) |=> (!locked && !mchk_o)); // R1
    AST_CLEAR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !fill_unc_i) |=> (!locked && !multi)); // R9
endmodule

// File: tb/tb_fill_err_capture.sv
module tb_fill_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_vld = 0, fill_unc = 0, fill_load = 0, fill_istr = 0;
    logic [28:0] fill_pa = '0;
    logic [1:0]  fill_qw = '0;
    logic [7:0]  fill_syn = '0;
    logic [63:0] fill_data = '0;
    logic [2:0]  ld_low = '0;
    logic [4:0]  ld_rn = '0;
    logic [3:0]  ld_type = '0;
    logic        wr_en = 0, wr_err = 0;
    logic [1:0]  wr_sel = '0, rd_sel = '0;
    logic [31:0] rd_data;
    logic        mchk, cache_valid;
    logic [63:0] cache_data;

    int checks = 0, errors = 0;

    // reference model state
    bit        m_lock, m_multi, m_istr, m_mchk;
    bit [1:0]  m_qw;
    bit [28:0] m_pa;
    bit [2:0]  m_low;
    bit [7:0]  m_syn;
    bit [4:0]  m_rn;
    bit [3:0]  m_lt;

    always #2 clk = ~clk;

    fill_err_capture dut (
        .clk(clk), .rst_n(rst_n), .fill_vld_i(fill_vld), .fill_unc_i(fill_unc),
        .fill_load_i(fill_load), .fill_istr_i(fill_istr), .fill_pa_i(fill_pa),
        .fill_qw_i(fill_qw), .fill_syn_i(fill_syn), .fill_data_i(fill_data),
        .ld_low_i(ld_low), .ld_rn_i(ld_rn), .ld_type_i(ld_type),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_err_i(wr_err), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .mchk_o(mchk), .cache_valid_o(cache_valid),
        .cache_data_o(cache_data)
    );

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [1:0] s);
        case (s)
            2'd0: return {27'd0, m_qw, m_istr, m_multi, m_lock};
            2'd1: return {m_pa, m_low};
            2'd2: return {24'd0, m_syn};
            default: return {23'd0, m_lt, m_rn};
        endcase
    endfunction

    task automatic model_update();
        bit err, clr;
        err = fill_vld && fill_unc && fill_load;
        clr = wr_en && wr_sel == 2'd0 && wr_err;
        m_mchk = 0;
        if (clr) begin m_lock = 0; m_multi = 0; end
        if (err) begin
            if (!m_lock) begin
                m_lock = 1; m_multi = 0; m_mchk = 1;
                m_istr = fill_istr; m_qw = fill_qw; m_pa = fill_pa; m_syn = fill_syn;
                if (fill_istr) m_low = 0;
                else begin m_low = ld_low; m_rn = ld_rn; m_lt = ld_type; end
            end else m_multi = 1;
        end
    endtask

    task automatic compare_all();
        chk("R2 mchk_o", 64'(mchk), 64'(m_mchk));
        chk("R10 cache_valid_o", 64'(cache_valid), 64'(fill_vld));
        chk("R10 cache_data_o", cache_data, fill_data);
        if (!(rd_sel == 2'd3 && m_istr))
            chk($sformatf("R5 R6 R7 R8 rd_data sel %0d", rd_sel), 64'(rd_data), 64'(model_read(rd_sel)));
    endtask

    task automatic step(bit v, bit u, bit ld, bit is, logic [28:0] pa, logic [1:0] qw,
                        logic [7:0] sy, logic [2:0] lo, logic [4:0] rn, logic [3:0] lt,
                        bit clr, logic [1:0] sel);
        fill_vld = v; fill_unc = u; fill_load = ld; fill_istr = is;
        fill_pa = pa; fill_qw = qw; fill_syn = sy; ld_low = lo; ld_rn = rn; ld_type = lt;
        fill_data = {$urandom, $urandom};
        wr_en = clr; wr_sel = 2'd0; wr_err = clr; rd_sel = sel;
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic read_reg(logic [1:0] sel, string tag, logic [31:0] exp);
        step(0, 0, 0, 0, '0, '0, '0, '0, '0, '0, 0, sel);
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 chk("R11 reset read", 64'(rd_data), 64'd0);
        end
        chk("R11 reset mchk", 64'(mchk), 64'd0);

        // R1 non-load fill with error, and load fill without error
        step(1, 1, 0, 0, 29'h1234567, 2'd1, 8'h5A, 3'd3, 5'd4, 4'h2, 0, 2'd0);
        step(1, 0, 1, 0, 29'h0ABCDEF, 2'd2, 8'hA5, 3'd1, 5'd7, 4'h1, 0, 2'd0);
        chk("R1 no capture on non-load", 64'(rd_data), 64'd0);

        // R2 R5 R6 R7 R8 first data-stream error
        step(1, 1, 1, 0, 29'h1F00F0F, 2'd3, 8'hC3, 3'd5, 5'd17, 4'b1001, 0, 2'd1);
        chk("R2 mchk after first error", 64'(mchk), 64'd1);
        chk("R5 R6 address reg", 64'(rd_data), 64'({29'h1F00F0F, 3'd5}));
        read_reg(2'd0, "R3 status dstream", {27'd0, 2'd3, 1'b0, 1'b0, 1'b1});
        chk("R2 mchk one cycle", 64'(mchk), 64'd0);
        read_reg(2'd2, "R7 syndrome", 32'hC3);
        read_reg(2'd3, "R8 load status", {23'd0, 4'b1001, 5'd17});

        // R4 second error while locked
        step(1, 1, 1, 1, 29'h0000001, 2'd0, 8'h11, 3'd2, 5'd3, 4'h4, 0, 2'd1);
        chk("R4 no mchk when locked", 64'(mchk), 64'd0);
        chk("R4 address frozen", 64'(rd_data), 64'({29'h1F00F0F, 3'd5}));
        read_reg(2'd0, "R4 multi bit", {27'd0, 2'd3, 1'b0, 1'b1, 1'b1});

        // R9 clear, then instruction-stream error
        step(0, 0, 0, 0, '0, '0, '0, '0, '0, '0, 1, 2'd0);
        chk("R9 cleared status", 64'(rd_data), 64'({27'd0, 2'd3, 3'b000}));
        step(1, 1, 1, 1, 29'h0777777, 2'd1, 8'h3C, 3'd6, 5'd9, 4'h8, 0, 2'd1);
        chk("R6 istream low bits zero", 64'(rd_data), 64'({29'h0777777, 3'd0}));
        read_reg(2'd0, "R3 status istream", {27'd0, 2'd1, 1'b1, 1'b0, 1'b1});

        // R9 clear and error in the same cycle
        step(1, 1, 1, 0, 29'h0ABCABC, 2'd2, 8'h99, 3'd4, 5'd30, 4'h3, 1, 2'd0);
        chk("R9 same-cycle recapture mchk", 64'(mchk), 64'd1);
        chk("R9 same-cycle status", 64'(rd_data), 64'({27'd0, 2'd2, 1'b0, 1'b0, 1'b1}));

        // randomized mix, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1), 29'($urandom), 2'($urandom), 8'($urandom),
                 3'($urandom), 5'($urandom), 4'($urandom), $urandom_range(0, 7) == 0,
                 2'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule